// File: doc/BRIEF.md
# Write-Only Two-Wire Display Slave

This block is the two-wire serial front end of a segment display controller. It watches the bus clock and data lines through a system-clock oversampler with a glitch filter. It recognises START and STOP conditions, and it answers only to its own 7-bit address, which two strap inputs complete. The acknowledge goes out on a separate pull-down enable rather than on the data line itself.

After the address, the master sends one or more control bytes. Bit 7 of a control byte says whether another control byte follows after the next payload byte. Bit 6 says whether the payload is a command or display data. Commands are forwarded on a one-cycle strobe. A command whose top two bits are both set also selects which of four row latches receives later display bytes. Display bytes leave on a byte write port as a row number, a byte index and 8 data bits. The index counts from the segment group at the top of the row down to the group at the bottom.

Top module: `dispI2cSlave`

## Requirements
- R1: When the first byte after START equals 0,1,1,0,0,addrSel[1],addrSel[0] followed by a 0 in bit 0 (the write direction), `ackPullEn` is high while SCL is high on the ninth clock of that byte. The same holds for every later byte of that transaction.
- R2: If the address differs or bit 0 is 1, `ackPullEn` stays low for that byte and for every later byte. No `wrEn` or `cmdValid` pulse occurs until the next START.
- R3: In a control byte, bit 7 is the continue flag and bit 6 is the payload type (0 = command, 1 = display data). Bits 5..0 have no effect.
- R4: When the continue flag is 1, exactly one payload byte follows and the next byte is again a control byte. When it is 0, every further byte until STOP or START is payload of the type last selected.
- R5: Each display byte gives a one-cycle `wrEn` pulse carrying `wrRow`, `wrIndex` and `wrData`. Index 0 covers segments 73..80, with `wrData[0]` on segment 73. Each next index is 8 segments lower. Index 9 covers segments 1..8 and is followed by index 0 again. The first display byte after START uses index 0.
- R6: A command with bits 7..6 = 11 sets the row to bits 1..0 (values 0..3) for later writes and sets the index back to 0. Bits 5..4 of that command are ignored. The row is 0 after reset and persists across transactions.
- R7: Every command byte appears unchanged on `cmdByte`, together with a one-cycle `cmdValid` pulse.
- R8: A pulse on SCL or SDA that lasts fewer than FILT_CYC (7) system clocks has no effect on acknowledges, writes or commands.
- R9: A repeated START in the middle of a byte discards the partial byte and begins a new address phase. After STOP, bits clocked without a START are ignored and get no acknowledge.
- R10: During and right after reset, `ackPullEn`, `wrEn` and `cmdValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line |
| addrSel | input | 2 | Strap bits completing the slave address |
| ackPullEn | output | 1 | Pull-down enable for the acknowledge pin |
| wrEn | output | 1 | Display byte write strobe |
| wrRow | output | 2 | Row latch selected for the write |
| wrIndex | output | 4 | Segment group index, 0 = segments 73..80 |
| wrData | output | 8 | Display bits, bit 0 = lowest segment of the group |
| cmdValid | output | 1 | Command strobe |
| cmdByte | output | 8 | Received command byte |

## Verification
Random transactions mix matching and non-matching addresses with random control, command and data bytes. A model of the control-byte state machine therefore sees every combination of the continue flag, the payload type and row-select commands, and it tells apart a wrong phase decision from a wrong index or row. Directed runs add:
- more than ten display bytes, which exposes the index wrap;
- a read-direction address and a wrong strap address, which separate the acknowledge from the address check;
- short pulses on both lines, including fake START and STOP edges on SDA while SCL is high;
- a repeated START after three bits;
- bits clocked after STOP without a START.

// File: rtl/dispI2cPkg.sv
package dispI2cPkg;
  localparam logic [4:0] ADDR_HI = 5'b01100;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_CTRL, PH_CMD, PH_DATA} phase_e;

  typedef struct packed {
    logic shiftEn;
    logic newXfer;
    logic cmdStb;
    logic dataStb;
  } dpStrobe_t;
endpackage

// File: rtl/i2cGlitchFilter.sv
module i2cGlitchFilter #(
  parameter int FILT_CYC = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CW = $clog2(FILT_CYC + 1);
  logic [1:0] syncQ;
  logic [CW-1:0] cnt;

  // a new level is taken only after FILT_CYC consecutive samples differ
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= 2'b11;
      lineOut <= 1'b1;
      cnt <= '0;
    end else begin
      syncQ <= {syncQ[0], lineIn};
      if (syncQ[1] == lineOut) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_CYC - 1)) begin
        lineOut <= syncQ[1];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dispI2cCtrl.sv
module dispI2cCtrl
  import dispI2cPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [1:0] addrSel,
  input  logic [7:0] rxByte,
  output dpStrobe_t  stb,
  output logic       ackPull
);
  phase_e phase;
  logic [2:0] bitCnt;
  logic [1:0] ackStage;
  logic coQ, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet, bitTake, byteDone;

  assign sclRise  = sclF & ~sclPrev;
  assign sclFall  = ~sclF & sclPrev;
  assign startDet = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopDet  = sclF & sclPrev & ~sdaPrev & sdaF;
  assign bitTake  = sclRise && (phase != PH_IDLE) && (ackStage == 2'd0);
  assign byteDone = bitTake && (bitCnt == 3'd7);

  always_comb begin
    stb.shiftEn = bitTake;
    stb.newXfer = startDet;
    stb.cmdStb  = byteDone && (phase == PH_CMD);
    stb.dataStb = byteDone && (phase == PH_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      bitCnt <= '0;
      ackStage <= '0;
      ackPull <= 1'b0;
      coQ <= 1'b0;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
      if (startDet) begin
        phase <= PH_ADDR;
        bitCnt <= '0;
        ackStage <= '0;
        ackPull <= 1'b0;
      end else if (stopDet) begin
        phase <= PH_IDLE;
        ackStage <= '0;
        ackPull <= 1'b0;
      end else begin
        if (bitTake) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == 3'd7) begin
            ackStage <= 2'd1;
            case (phase)
              PH_ADDR: begin
                if (rxByte == {ADDR_HI, addrSel, 1'b0}) begin
                  phase <= PH_CTRL;
                end else begin
                  phase <= PH_IDLE;
                  ackStage <= 2'd0;
                end
              end
              PH_CTRL: begin
                coQ <= rxByte[7];
                phase <= rxByte[6] ? PH_DATA : PH_CMD;
              end
              default: if (coQ) phase <= PH_CTRL;
            endcase
          end
        end
        if (sclFall && ackStage == 2'd1) begin
          ackPull <= 1'b1;
          ackStage <= 2'd2;
        end else if (sclFall && ackStage == 2'd2) begin
          ackPull <= 1'b0;
          ackStage <= 2'd0;
        end
      end
    end
  end
endmodule

// File: rtl/dispI2cDatapath.sv
module dispI2cDatapath
  import dispI2cPkg::*;
#(
  parameter int NBYTES = 10,
  parameter int IDXW = 4,
  parameter int ROWW = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sdaF,
  input  dpStrobe_t       stb,
  output logic [7:0]      rxByte,
  output logic            wrEn,
  output logic [ROWW-1:0] wrRow,
  output logic [IDXW-1:0] wrIndex,
  output logic [7:0]      wrData,
  output logic            cmdValid,
  output logic [7:0]      cmdByte
);
  logic [7:0] shiftQ;
  logic [ROWW-1:0] rowQ;
  logic [IDXW-1:0] idxQ;

  assign rxByte = {shiftQ[6:0], sdaF};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      rowQ <= '0;
      idxQ <= '0;
      wrEn <= 1'b0;
      wrRow <= '0;
      wrIndex <= '0;
      wrData <= '0;
      cmdValid <= 1'b0;
      cmdByte <= '0;
    end else begin
      wrEn <= 1'b0;
      cmdValid <= 1'b0;
      if (stb.shiftEn) shiftQ <= rxByte;
      if (stb.newXfer) idxQ <= '0;
      if (stb.cmdStb) begin
        cmdValid <= 1'b1;
        cmdByte <= rxByte;
        if (rxByte[7:6] == 2'b11) begin
          rowQ <= rxByte[ROWW-1:0];
          idxQ <= '0;
        end
      end
      if (stb.dataStb) begin
        wrEn <= 1'b1;
        wrRow <= rowQ;
        wrIndex <= idxQ;
        wrData <= rxByte;
        idxQ <= (idxQ == IDXW'(NBYTES - 1)) ? '0 : idxQ + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dispI2cSlave.sv
module dispI2cSlave
  import dispI2cPkg::*;
#(
  parameter int NSEG = 80,
  parameter int ROWS = 4,
  parameter int FILT_CYC = 7,
  localparam int NBYTES = NSEG / BYTE_W,
  localparam int IDXW = $clog2(NBYTES),
  localparam int ROWW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclIn,
  input  logic            sdaIn,
  input  logic [1:0]      addrSel,
  output logic            ackPullEn,
  output logic            wrEn,
  output logic [ROWW-1:0] wrRow,
  output logic [IDXW-1:0] wrIndex,
  output logic [7:0]      wrData,
  output logic            cmdValid,
  output logic [7:0]      cmdByte
);
  logic [1:0] rawLine, filtLine;
  logic sclF, sdaF;
  logic [7:0] rxByte;
  dpStrobe_t stb;

  assign rawLine = {sclIn, sdaIn};
  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2cGlitchFilter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rstN(rstN), .lineIn(rawLine[g]), .lineOut(filtLine[g]));
  end
  assign sdaF = filtLine[0];
  assign sclF = filtLine[1];

  dispI2cCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF), .addrSel(addrSel),
    .rxByte(rxByte), .stb(stb), .ackPull(ackPullEn));

  dispI2cDatapath #(.NBYTES(NBYTES), .IDXW(IDXW), .ROWW(ROWW)) u_dp (
    .clk(clk), .rstN(rstN), .sdaF(sdaF), .stb(stb), .rxByte(rxByte),
    .wrEn(wrEn), .wrRow(wrRow), .wrIndex(wrIndex), .wrData(wrData),
    .cmdValid(cmdValid), .cmdByte(cmdByte));
endmodule

// File: rtl/dispI2cSlaveChk.sv
module dispI2cSlaveChk #(
  parameter int NBYTES = 10,
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            sclFilt,
  input logic            ackPullEn,
  input logic            wrEn,
  input logic [IDXW-1:0] wrIndex,
  input logic            cmdValid
);
  // R3: a byte is either a command or display data, never both
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && cmdValid));
  // R5: write strobe is a single-cycle pulse
  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);
  // R5: index never leaves the row
  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrIndex < IDXW'(NBYTES)));
  // R7: command strobe is a single-cycle pulse
  p_cmd_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);
  // R1: acknowledge only begins while the clock is low
  p_ack_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackPullEn) |-> !sclFilt);
  // R8: strobes follow a filtered clock rise only
  p_wr_on_scl_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn || cmdValid) |-> sclFilt);
endmodule

bind dispI2cSlave dispI2cSlaveChk #(.NBYTES(NBYTES), .IDXW(IDXW)) chk_i (
  .clk(clk), .rstN(rstN), .sclFilt(sclF), .ackPullEn(ackPullEn),
  .wrEn(wrEn), .wrIndex(wrIndex), .cmdValid(cmdValid));

// File: tb/dispI2cSlave_tb.sv
module dispI2cSlave_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic [1:0] addrSel = 2'b10;
  logic ackPullEn, wrEn, cmdValid;
  logic [1:0] wrRow;
  logic [3:0] wrIndex;
  logic [7:0] wrData, cmdByte;

  always #4 clk = ~clk;

  dispI2cSlave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sda), .addrSel(addrSel),
    .ackPullEn(ackPullEn), .wrEn(wrEn), .wrRow(wrRow), .wrIndex(wrIndex),
    .wrData(wrData), .cmdValid(cmdValid), .cmdByte(cmdByte));

  int nChecks = 0, nFails = 0;
  logic [13:0] gotWr [64];
  logic [13:0] expWr [64];
  logic [7:0] gotCmd [64];
  logic [7:0] expCmd [64];
  logic gotAck [16];
  logic expAck [16];
  int nWr = 0, nExpWr = 0, nCmd = 0, nExpCmd = 0;
  int mRow = 0, mIdx = 0;

  always @(negedge clk) begin
    if (wrEn && nWr < 64) begin gotWr[nWr] = {wrRow, wrIndex, wrData}; nWr++; end
    if (cmdValid && nCmd < 64) begin gotCmd[nCmd] = cmdByte; nCmd++; end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2cBit(input logic v, input bit g);
    waitc(8); sda = v; waitc(4);
    if (g) begin scl = 1'b1; waitc(4); scl = 1'b0; end  // R8 clock glitch
    waitc(8);
    scl = 1'b1; waitc(10);
    if (g) begin sda = ~v; waitc(4); sda = v; end      // R8 fake start/stop
    waitc(10);
    scl = 1'b0;
  endtask

  task automatic i2cByte(input logic [7:0] b, input bit g, output logic ack);
    for (int i = 7; i >= 0; i--) i2cBit(b[i], g);
    waitc(8); sda = 1'b1; waitc(8);
    scl = 1'b1; waitc(12); ack = ackPullEn; waitc(12);
    scl = 1'b0;
  endtask

  task automatic i2cStart();
    if (!scl) begin sda = 1'b1; waitc(8); scl = 1'b1; waitc(12); end
    sda = 1'b0; waitc(12); scl = 1'b0;
  endtask

  task automatic i2cStop();
    waitc(8); sda = 1'b0; waitc(8); scl = 1'b1; waitc(12); sda = 1'b1; waitc(16);
  endtask

  task automatic clearAll();
    nWr = 0; nExpWr = 0; nCmd = 0; nExpCmd = 0;
  endtask

  // expected behaviour from R1..R7
  task automatic modelXfer(input int n, input logic [7:0] b [16]);
    int ph = 1;  // 0 idle, 1 addr, 2 ctrl, 3 cmd, 4 data
    bit co = 0;
    mIdx = 0;
    for (int i = 0; i < n; i++) begin
      expAck[i] = 1'b0;
      case (ph)
        1: if (b[i] == {5'b01100, addrSel, 1'b0}) begin expAck[i] = 1'b1; ph = 2; end
           else ph = 0;
        2: begin expAck[i] = 1'b1; co = b[i][7]; ph = b[i][6] ? 4 : 3; end
        3: begin
             expAck[i] = 1'b1; expCmd[nExpCmd] = b[i]; nExpCmd++;
             if (b[i][7:6] == 2'b11) begin mRow = b[i][1:0]; mIdx = 0; end
             if (co) ph = 2;
           end
        4: begin
             expAck[i] = 1'b1;
             expWr[nExpWr] = {mRow[1:0], mIdx[3:0], b[i]}; nExpWr++;
             mIdx = (mIdx == 9) ? 0 : mIdx + 1;
             if (co) ph = 2;
           end
        default: ;
      endcase
    end
  endtask

  task automatic busXfer(input int n, input logic [7:0] b [16], input bit g);
    i2cStart();
    for (int i = 0; i < n; i++) i2cByte(b[i], g, gotAck[i]);
    i2cStop();
    waitc(20);
  endtask

  task automatic compareAll(input int n, input string tag);
    for (int i = 0; i < n; i++)
      check(gotAck[i] === expAck[i], {tag, " R1 R2 ack"}, int'(gotAck[i]), int'(expAck[i]));
    check(nWr == nExpWr, {tag, " R5 write count"}, nWr, nExpWr);
    for (int i = 0; i < nWr && i < nExpWr; i++)
      check(gotWr[i] === expWr[i], {tag, " R5 R6 write"}, int'(gotWr[i]), int'(expWr[i]));
    check(nCmd == nExpCmd, {tag, " R7 command count"}, nCmd, nExpCmd);
    for (int i = 0; i < nCmd && i < nExpCmd; i++)
      check(gotCmd[i] === expCmd[i], {tag, " R7 command"}, int'(gotCmd[i]), int'(expCmd[i]));
  endtask

  task automatic runXfer(input int n, input logic [7:0] b [16], input bit g, input string tag);
    clearAll();
    modelXfer(n, b);
    busXfer(n, b, g);
    compareAll(n, tag);
  endtask

  logic [7:0] bb [16];
  logic dummyAck;

  initial begin
    void'($urandom(32'd4242));
    waitc(5);
    rstN = 1'b1;
    waitc(2);
    check(ackPullEn == 1'b0 && wrEn == 1'b0 && cmdValid == 1'b0, "R10 reset outputs",
          {ackPullEn, wrEn, cmdValid}, 0);
    waitc(20);

    // R5 R4: streamed data past the end of the row wraps the index
    bb[0] = 8'h64; bb[1] = 8'h40;
    for (int i = 2; i < 14; i++) bb[i] = 8'(8'h11 * i);
    runXfer(14, bb, 1'b0, "R4 R5 stream");

    // R3: low bits of the control byte are ignored
    bb[1] = 8'h7F; bb[2] = 8'hA5; bb[3] = 8'h5A;
    runXfer(4, bb, 1'b0, "R3 ctrl low bits");

    // R2: wrong strap address, then read direction
    bb[0] = 8'h66; bb[1] = 8'h40; bb[2] = 8'hFF;
    runXfer(3, bb, 1'b0, "R2 address mismatch");
    bb[0] = 8'h65;
    runXfer(3, bb, 1'b0, "R2 read direction");

    // R4 R6 R7: continue flag mixes commands and data; strap field of the command ignored
    bb[0] = 8'h64; bb[1] = 8'h80; bb[2] = 8'hE6; bb[3] = 8'hC0; bb[4] = 8'h3C;
    bb[5] = 8'h80; bb[6] = 8'hF5; bb[7] = 8'h40; bb[8] = 8'h81; bb[9] = 8'h18;
    runXfer(10, bb, 1'b0, "R4 R6 R7 mixed");

    // R8: glitches on both lines
    bb[0] = 8'h64; bb[1] = 8'h40; bb[2] = 8'h96; bb[3] = 8'h69; bb[4] = 8'h0F;
    runXfer(5, bb, 1'b1, "R8 glitch");

    // R9: repeated start after three bits discards the partial byte
    clearAll();
    bb[0] = 8'h64; bb[1] = 8'h40; bb[2] = 8'hC3;
    modelXfer(3, bb);
    i2cStart();
    i2cByte(8'h64, 1'b0, dummyAck);
    i2cByte(8'h40, 1'b0, dummyAck);
    i2cBit(1'b1, 1'b0); i2cBit(1'b0, 1'b1); i2cBit(1'b1, 1'b0);
    busXfer(3, bb, 1'b0);
    compareAll(3, "R9 repeated start");

    // R9: bits after STOP without START are ignored
    clearAll();
    scl = 1'b0; waitc(8);
    i2cByte(8'h64, 1'b0, gotAck[0]);
    i2cByte(8'h40, 1'b0, gotAck[1]);
    i2cByte(8'h55, 1'b0, gotAck[2]);
    sda = 1'b1; waitc(8); scl = 1'b1; waitc(20);
    check(gotAck[0] == 1'b0 && gotAck[1] == 1'b0, "R9 idle ack", int'(gotAck[0]), 0);
    check(nWr == 0 && nCmd == 0, "R9 idle writes", nWr + nCmd, 0);

    // random transactions, model-checked (R1..R7)
    for (int t = 0; t < 20; t++) begin
      int n;
      addrSel = 2'($urandom_range(3));
      n = $urandom_range(2, 10);
      bb[0] = ($urandom_range(9) == 0) ? 8'(8'h60 | $urandom_range(15)) : {5'b01100, addrSel, 1'b0};
      for (int i = 1; i < n; i++) bb[i] = 8'($urandom());
      runXfer(n, bb, 1'b0, "R1 R3 R4 random");
    end

    summary();
    $finish;
  end
endmodule